// File: doc/BRIEF.md
# Polled SPI Master with Two-Step Completion Handshake

This peripheral sits on a small synchronous register bus and runs one full-duplex 8-bit SPI exchange at a time. Software first sets a control byte that selects the SCK rate, the clock idle level and the sampling phase. Writing a byte to the data offset then starts the exchange. One shift register carries the transmit byte out on MOSI, most significant bit first, and collects the MISO bits in its place. There are therefore no separate transmit-empty or receive-full flags.

On the final SCK edge the received byte is copied into a read buffer and a completion flag is raised. The flag can also drive an interrupt request. Software acknowledges the flag in two steps: first any access to the status offset, then a read of the data offset. Until the status offset has been touched, new data writes are ignored. Slave select is left to a general-purpose output outside this block.

Top module: `spi_hs_master`

## Requirements
- R1: A write to offset 2 while idle, enabled and not locked starts an exchange of exactly eight SCK pulses, and the byte leaves on MOSI most significant bit first.
- R2: The byte sampled on MISO during the exchange, first bit as most significant, is what a read of offset 2 returns after completion.
- R3: While no exchange is running, SCK rests at the CPOL value, which is control bit 3. After the last pulse, SCK is back at that level.
- R4: With CPHA (control bit 2) clear, MOSI is valid before the first SCK edge and both sides sample on odd edges. With CPHA set, both sides sample on even edges and MOSI changes on odd edges.
- R5: Control bits 1:0, with values 0, 1, 2 and 3, give an SCK half-period of 2, 4, 8 and 16 system clocks. This is a division by 4, 8, 16 and 32. The first edge comes one half-period after the starting write.
- R6: Status bit 7 is set in the same clock as the last SCK edge, and the read buffer changes only then. Reads of offset 2 return the buffer.
- R7: irq_o is high exactly when status bit 7 is set, control bit 7 (interrupt enable) is set and irq_mask_i is low.
- R8: Status bit 7 clears only on a read of offset 2 that follows a read or write of offset 1 made while the bit was set. A read of offset 2 alone leaves it set.
- R9: While status bit 7 is set and offset 1 has not yet been accessed, writes to offset 2 start nothing.
- R10: A write to offset 2 during an exchange is ignored, and the running exchange completes unchanged.
- R11: The control byte reads back at offset 0. While control bit 6 (enable) is clear, writes to offset 2 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe for this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset: 0 control, 1 status, 2 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected offset, combinational |
| irq_mask_i | input | 1 | Global interrupt mask, high blocks irq_o |
| irq_o | output | 1 | Completion interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
All register effects take hold at the clock edge that ends the bus access. The reference model updates at that same edge, and rdata_o is compared during the access cycle itself, because the read path is combinational. The first SCK transition comes one half-period of system clocks after the accepting edge and is followed by fifteen more at the same spacing. The completion flag, the buffer and irq_o all change at the clock edge of the sixteenth transition. The model counts these clocks itself, and sck_o and irq_o are compared against it after every falling clock edge. A bench slave responds to the actual SCK edges, so the MOSI byte and the MISO sampling phase are checked by value for all four modes.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  // register offsets
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_DATA = 2;
  // control field positions
  localparam int CTL_RATE = 0;
  localparam int CTL_CPHA = 2;
  localparam int CTL_CPOL = 3;
  localparam int CTL_EN   = 6;
  localparam int CTL_IE   = 7;
  // status field positions
  localparam int STAT_DONE = 7;
endpackage

// File: rtl/spi_hs_sckgen.sv
module spi_hs_sckgen #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              lead_o,
  output logic              trail_o,
  output logic              last_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam int CNT_W = (1 << RATE_W) + 1;

  logic             busy_q, sck_q, tick;
  logic [CNT_W-1:0] cnt_q, half;
  logic [EW-1:0]    edge_q;

  assign half    = CNT_W'(2) << rate_i;
  assign tick    = busy_q && (cnt_q == half - CNT_W'(1));
  assign lead_o  = tick && !edge_q[0];
  assign trail_o = tick && edge_q[0];
  assign last_o  = tick && (edge_q == EW'(EDGES - 1));
  assign busy_o  = busy_q;
  assign sck_o   = busy_q ? sck_q : cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sck_q  <= cpol_i;
      cnt_q  <= '0;
      edge_q <= '0;
    end else if (busy_q) begin
      if (tick) begin
        cnt_q  <= '0;
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EW'(1);
        if (last_o) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // SCK back at idle level once the pulse train ends (R3)
  assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (sck_q == cpol_i));

  // SCK moves only on divider ticks (R5)
  assert_sck_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick && !start_i) |=> $stable(sck_q));
endmodule

// File: rtl/spi_hs_shift.sv
module spi_hs_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              cpha_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] sreg_q;
  logic              out_q, samp_q, in_bit;

  // phase 0 samples on lead and shifts on trail; phase 1 drives on lead, samples+shifts on trail
  assign in_bit = cpha_i ? miso_i : samp_q;
  assign next_o = {sreg_q[DATA_W-2:0], in_bit};
  assign mosi_o = cpha_i ? out_q : sreg_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      out_q  <= 1'b0;
      samp_q <= 1'b0;
    end else if (load_i) begin
      sreg_q <= load_data_i;
      out_q  <= load_data_i[DATA_W-1];
      samp_q <= 1'b0;
    end else begin
      if (lead_i) begin
        if (cpha_i) out_q  <= sreg_q[DATA_W-1];
        else        samp_q <= miso_i;
      end
      if (trail_i) sreg_q <= next_o;
    end
  end

  // MOSI holds across the sampling edge in both phases (R4)
  assert_mosi_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpha_i ? trail_i : lead_i) && !load_i) |=> ($stable(mosi_o) || (cpha_i != $past(cpha_i))));
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              irq_mask_i,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic [DATA_W-1:0] ctrl_q, rbuf_q, rx_next, stat_w;
  logic flag_q, armed_q;
  logic busy, lead, trail, last, start, lock;
  logic wr_ctrl, wr_data, rd_data, acc_stat;

  assign wr_ctrl  = sel_i &&  wr_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_data  = sel_i &&  wr_i && (addr_i == ADDR_W'(REG_DATA));
  assign rd_data  = sel_i && !wr_i && (addr_i == ADDR_W'(REG_DATA));
  assign acc_stat = sel_i && (addr_i == ADDR_W'(REG_STAT));
  assign lock     = flag_q && !armed_q;
  assign start    = wr_data && !busy && ctrl_q[CTL_EN] && !lock;

  spi_hs_sckgen #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_sckgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cpol_i  (ctrl_q[CTL_CPOL]),
    .rate_i  (ctrl_q[CTL_RATE +: RATE_W]),
    .busy_o  (busy),
    .sck_o   (sck_o),
    .lead_o  (lead),
    .trail_o (trail),
    .last_o  (last)
  );

  spi_hs_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_data_i (wdata_i),
    .cpha_i      (ctrl_q[CTL_CPHA]),
    .lead_i      (lead),
    .trail_i     (trail),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .next_o      (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rbuf_q  <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (last) begin
        rbuf_q  <= rx_next;
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (rd_data && flag_q && armed_q) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (acc_stat && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_w            = '0;
    stat_w[STAT_DONE] = flag_q;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(REG_CTRL): rdata_o = ctrl_q;
      ADDR_W'(REG_STAT): rdata_o = stat_w;
      ADDR_W'(REG_DATA): rdata_o = rbuf_q;
      default:           rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ctrl_q[CTL_IE] && !irq_mask_i;

  assert_clear_needs_stat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q && rd_data));

  assert_locked_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && lock && !busy) |=> !busy);

  assert_busy_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_data && !last) |=> busy);

  assert_done_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> flag_q);

  assert_buf_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(rbuf_q));
endmodule

// File: tb/sim_spi_hs_master.sv
module sim_spi_hs_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_mask = 1'b0;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int errs = 0, checks = 0, cyc = 0;

  // reference model state
  logic [7:0] m_ctrl = 8'd0, m_rbuf = 8'd0;
  logic       m_flag = 1'b0, m_armed = 1'b0, m_busy = 1'b0, m_sck = 1'b0;
  int         m_cnt = 0;

  // bench slave
  logic [7:0] slv_tx = 8'd0, slv_rx = 8'd0;
  int         slv_n = 8;
  logic       prev_sck = 1'b0;

  spi_hs_master u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sel_i      (sel),
    .wr_i       (wr),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_mask_i (irq_mask),
    .irq_o      (irq),
    .sck_o      (sck),
    .mosi_o     (mosi),
    .miso_i     (miso)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // behavioural reference, updated at each rising edge from pre-edge values
  always @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rbuf = 0; m_flag = 0; m_armed = 0; m_busy = 0; m_sck = 0; m_cnt = 0;
    end else begin
      automatic int   half  = 2 << m_ctrl[1:0];
      automatic logic of    = m_flag;
      automatic logic oa    = m_armed;
      automatic logic done  = 1'b0;
      automatic logic acc   = sel && wr && addr == 2 && !m_busy && m_ctrl[6] && !(of && !oa);
      if (m_busy) begin
        m_cnt++;
        if (m_cnt % half == 0) m_sck = !m_sck;
        if (m_cnt == 16 * half) begin
          m_busy = 0; done = 1; m_rbuf = slv_tx;
        end
      end
      if (acc) begin
        m_busy = 1; m_cnt = 0; m_sck = m_ctrl[3];
      end
      if (sel && wr && addr == 0) m_ctrl = wdata;
      if (done) begin
        m_flag = 1; m_armed = 0;
      end else if (sel && !wr && addr == 2 && of && oa) begin
        m_flag = 0; m_armed = 0;
      end else if (sel && addr == 1 && of) begin
        m_armed = 1;
      end
    end
  end

  // slave: reacts to the DUT's SCK transitions
  always @(negedge clk_i) begin
    if (sck !== prev_sck && slv_n < 8) begin
      automatic logic lead = (sck != m_ctrl[3]);
      if (lead ^ m_ctrl[2]) begin
        slv_rx = {slv_rx[6:0], mosi};
        slv_n++;
      end else if (slv_n < 8) begin
        miso = slv_tx[7 - slv_n];
      end
    end
    prev_sck = sck;
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    #1;
    if (rst_n) begin
      chk(sck === (m_busy ? m_sck : m_ctrl[3]), "R3 R5 sck", sck, m_busy ? m_sck : m_ctrl[3]);
      chk(irq === (m_flag && m_ctrl[7] && !irq_mask), "R7 irq", irq, m_flag && m_ctrl[7] && !irq_mask);
      if (sel && !wr) begin
        case (addr)
          2'd0: chk(rdata === m_ctrl, "R11 ctrl readback", rdata, m_ctrl);
          2'd1: chk(rdata === {m_flag, 7'd0}, "R8 status", rdata, {m_flag, 7'd0});
          2'd2: chk(rdata === m_rbuf, "R2 R6 data", rdata, m_rbuf);
          default: ;
        endcase
      end
    end
  end

  task automatic bus(input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    sel = 1; wr = w; addr = a; wdata = d;
    @(negedge clk_i);
    sel = 0; wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && m_busy; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic arm_slave(input logic [7:0] stx);
    slv_tx = stx; slv_n = 0; slv_rx = 0; miso = stx[7];
  endtask

  task automatic xfer(input logic cpol, input logic cpha, input logic [1:0] rate,
                      input logic [7:0] tx, input logic [7:0] stx);
    bus(1, 0, {2'b11, 2'b00, cpol, cpha, rate});
    arm_slave(stx);
    bus(1, 2, tx);
    wait_idle();
    chk(slv_n == 8, "R1 pulse count", slv_n, 8);
    chk(slv_rx == tx, "R1 R4 mosi byte", slv_rx, tx);
    chk(m_flag, "R6 flag set", m_flag, 1);
    bus(0, 1, 0);
    bus(0, 2, 0);
    bus(0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sck === 1'b0 && irq === 1'b0 && rdata === 8'd0, "R3 reset state", {sck, irq}, 0);
    rst_n = 1;
    bus(0, 0, 0);
    bus(0, 1, 0);

    // four modes, four rates
    xfer(0, 0, 2'd0, 8'hA5, 8'h3C);
    xfer(0, 1, 2'd1, 8'h96, 8'h5A);
    xfer(1, 0, 2'd2, 8'h0F, 8'hF0);
    xfer(1, 1, 2'd3, 8'hC3, 8'h81);
    xfer(0, 0, 2'd3, 8'h01, 8'h80);

    // R9: pending flag blocks data writes until status touched
    bus(1, 0, 8'hC0);
    arm_slave(8'h77);
    bus(1, 2, 8'h12);
    wait_idle();
    chk(m_flag, "R6 flag set", m_flag, 1);
    arm_slave(8'h44);
    bus(1, 2, 8'h34);
    repeat (20) @(negedge clk_i);
    chk(slv_n == 0, "R9 locked write ignored", slv_n, 0);
    bus(0, 2, 0);
    chk(m_flag && rdata === 8'h77, "R8 data read alone keeps flag", rdata, 8'h77);
    bus(0, 1, 0);
    bus(1, 2, 8'h5C);
    wait_idle();
    chk(slv_n == 8 && slv_rx == 8'h5C, "R9 write after status", slv_rx, 8'h5C);
    bus(0, 1, 0);
    bus(0, 2, 0);
    bus(0, 1, 0);

    // R10: write during a running exchange
    bus(1, 0, 8'hC2);
    arm_slave(8'hE7);
    bus(1, 2, 8'h6B);
    repeat (10) @(negedge clk_i);
    bus(1, 2, 8'h00);
    wait_idle();
    chk(slv_rx == 8'h6B, "R10 busy write ignored", slv_rx, 8'h6B);
    bus(0, 2, 0);

    // R7: mask and enable gate the request
    irq_mask = 1;
    repeat (4) @(negedge clk_i);
    chk(irq === 1'b0, "R7 masked", irq, 0);
    irq_mask = 0;
    bus(1, 0, 8'h42);
    repeat (2) @(negedge clk_i);
    chk(irq === 1'b0, "R7 ie clear", irq, 0);
    bus(1, 0, 8'hC2);
    repeat (2) @(negedge clk_i);
    chk(irq === 1'b1, "R7 request", irq, 1);
    bus(0, 1, 0);
    bus(0, 2, 0);

    // R11: enable clear blocks start
    bus(1, 0, 8'h88);
    arm_slave(8'h11);
    bus(1, 2, 8'h22);
    repeat (20) @(negedge clk_i);
    chk(slv_n == 0 && sck === 1'b1, "R11 disabled write ignored", slv_n, 0);
    slv_n = 8;

    repeat (5) @(negedge clk_i);
    finish_run();
  end
endmodule